// File: doc/BRIEF.md
# Stack and Subroutine Call Engine

This block keeps the stack of a small 8-bit controller in its own internal data RAM and sequences the four stack operations: push a byte, pop a byte, call a subroutine and return from one. The stack grows upward. A pointer register names the most recently written entry. It starts at 07H after reset and wraps modulo the RAM size.

The rest of the core starts an operation with a one-cycle command strobe. For a push it supplies the byte. For a call it supplies the return address, meaning the address of the instruction after the call, together with the destination. A call stores the return address as two bytes over two successive RAM cycles and then presents the destination as the new program counter. A return reads the two bytes back over two RAM cycles and presents the restored program counter. The RAM uses a synchronous read, so it maps onto block memory. While a multi-cycle operation is in progress `busy` is high and any new command is dropped. A one-cycle `done` pulse marks the cycle in which a result is valid.

Top module: `stack_call_unit`

## Requirements
- R1: After synchronous reset, `sp_out` is 07H and `busy`, `done`, `pop_data` and `pc_out` are all zero.
- R2: A push (cmd_op 2'b00) accepted at a clock edge first adds one to the pointer and then writes `push_data` at the new address. After that edge `done` is 1, `busy` is 0 and `sp_out` shows the new pointer.
- R3: A pop (cmd_op 2'b01) reads the byte at the current pointer and then subtracts one from the pointer. After the accepting edge `busy` is 1 and `done` is 0. After the next edge `done` is 1, `busy` is 0 and `pop_data` holds the byte that was read.
- R4: A call (cmd_op 2'b10) writes `ret_pc[7:0]` at pointer+1 in its first cycle and `ret_pc[15:8]` at pointer+2 in its second. The pointer ends two higher. After the second edge `done` is 1 and `pc_out` equals `call_tgt`.
- R5: A return (cmd_op 2'b11) reads the byte at the pointer as the high byte of the PC and the byte at pointer-1 as the low byte. The pointer ends two lower. After the third edge `done` is 1 and `pc_out` holds the restored address.
- R6: While `busy` is 1, a command on `cmd_valid` is ignored. It changes neither the pointer nor the stack contents.
- R7: Pointer arithmetic wraps modulo 256. A push at FFH writes address 00H, and a pop at 00H leaves FFH.
- R8: `done` is a single-cycle pulse per operation. `pc_out` and `pop_data` change only in a cycle where `done` is 1 and otherwise hold their values.
- R9: Starting from pointer 3AH, a call with return address 0207H stores 07H at 3BH and 02H at 3CH and leaves the pointer at 3CH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only while busy is 0 |
| cmd_op | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| push_data | input | 8 | Byte to push |
| ret_pc | input | 16 | Return address saved by a call |
| call_tgt | input | 16 | Destination loaded into the PC by a call |
| pop_data | output | 8 | Byte from the last pop |
| pc_out | output | 16 | New PC after a call or return |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default 8-bit address and 8-bit data widths, so the whole 256-entry ring is in play. A full sweep pushes 256 computed bytes and pops them back, which carries the pointer through FFH to 00H and back again. Nested calls with arithmetically generated return addresses, followed by the matching returns, check the byte order of both operations. Commands driven during busy cycles check that they are dropped. The expected values come from the worked pointer example and from a simple array model kept in the bench.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_POP_RD  = 3'd1,
    ST_CALL_HI = 3'd2,
    ST_RET_HI  = 3'd3,
    ST_RET_LO  = 3'd4
  } stk_state_e;
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // write port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, old data on collision
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stk_pointer.sv
module stk_pointer #(
  parameter int          AW      = 8,
  parameter logic [7:0]  RST_VAL = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_up
);
  localparam logic [AW-1:0] ONE = AW'(1);

  assign sp_up = sp + ONE;

  always_ff @(posedge clk) begin
    if (rst)      sp <= AW'(RST_VAL);
    else if (inc) sp <= sp + ONE;
    else if (dec) sp <= sp - ONE;
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [DW-1:0]   push_data,
  input  logic [2*DW-1:0] ret_pc,
  input  logic [2*DW-1:0] call_tgt,
  input  logic [AW-1:0]   sp,
  input  logic [AW-1:0]   sp_up,
  input  logic [DW-1:0]   rd_data,
  output logic            sp_inc,
  output logic            sp_dec,
  output logic            ram_we,
  output logic [AW-1:0]   ram_waddr,
  output logic [DW-1:0]   ram_wdata,
  output logic [AW-1:0]   ram_raddr,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   pop_data,
  output logic [2*DW-1:0] pc_out
);
  localparam int PCW = 2 * DW;

  stk_state_e state, nxt;
  stk_op_e    op;
  logic       accept;
  logic [DW-1:0]  hold_hi;
  logic [PCW-1:0] hold_tgt;
  logic [DW-1:0]  ret_hi_q;

  assign op     = stk_op_e'(cmd_op);
  assign accept = cmd_valid && (state == ST_IDLE);

  always_comb begin
    nxt       = state;
    sp_inc    = 1'b0;
    sp_dec    = 1'b0;
    ram_we    = 1'b0;
    ram_waddr = sp_up;
    ram_wdata = push_data;
    ram_raddr = sp;
    case (state)
      ST_IDLE: begin
        if (cmd_valid) begin
          case (op)
            OP_PUSH: begin
              ram_we = 1'b1;
              sp_inc = 1'b1;
            end
            OP_POP: begin
              sp_dec = 1'b1;
              nxt    = ST_POP_RD;
            end
            OP_CALL: begin
              ram_we    = 1'b1;
              ram_wdata = ret_pc[DW-1:0];
              sp_inc    = 1'b1;
              nxt       = ST_CALL_HI;
            end
            default: begin
              sp_dec = 1'b1;
              nxt    = ST_RET_HI;
            end
          endcase
        end
      end
      ST_POP_RD:  nxt = ST_IDLE;
      ST_CALL_HI: begin
        ram_we    = 1'b1;
        ram_wdata = hold_hi;
        sp_inc    = 1'b1;
        nxt       = ST_IDLE;
      end
      ST_RET_HI: begin
        sp_dec = 1'b1;
        nxt    = ST_RET_LO;
      end
      ST_RET_LO: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      pop_data <= '0;
      pc_out   <= '0;
      hold_hi  <= '0;
      hold_tgt <= '0;
      ret_hi_q <= '0;
    end else begin
      state <= nxt;
      busy  <= (nxt != ST_IDLE);
      done  <= (accept && op == OP_PUSH) || (state == ST_POP_RD) ||
               (state == ST_CALL_HI) || (state == ST_RET_LO);
      if (accept && op == OP_CALL) begin
        hold_hi  <= ret_pc[PCW-1:DW];
        hold_tgt <= call_tgt;
      end
      if (state == ST_POP_RD)  pop_data <= rd_data;
      if (state == ST_CALL_HI) pc_out   <= hold_tgt;
      if (state == ST_RET_HI)  ret_hi_q <= rd_data;
      if (state == ST_RET_LO)  pc_out   <= {ret_hi_q, rd_data};
    end
  end
endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit #(
  parameter int         AW      = 8,
  parameter int         DW      = 8,
  parameter logic [7:0] SP_RST  = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [DW-1:0]   push_data,
  input  logic [2*DW-1:0] ret_pc,
  input  logic [2*DW-1:0] call_tgt,
  output logic [DW-1:0]   pop_data,
  output logic [2*DW-1:0] pc_out,
  output logic [AW-1:0]   sp_out,
  output logic            busy,
  output logic            done
);
  logic          sp_inc, sp_dec, ram_we;
  logic [AW-1:0] sp, sp_up, ram_waddr, ram_raddr;
  logic [DW-1:0] ram_wdata, ram_rdata;

  stk_pointer #(.AW(AW), .RST_VAL(SP_RST)) ptr_i (
    .clk(clk), .rst(rst), .inc(sp_inc), .dec(sp_dec),
    .sp(sp), .sp_up(sp_up)
  );

  stk_ram #(.AW(AW), .DW(DW)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  stk_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .push_data(push_data), .ret_pc(ret_pc), .call_tgt(call_tgt),
    .sp(sp), .sp_up(sp_up), .rd_data(ram_rdata),
    .sp_inc(sp_inc), .sp_dec(sp_dec), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .ram_raddr(ram_raddr),
    .busy(busy), .done(done), .pop_data(pop_data), .pc_out(pc_out)
  );

  assign sp_out = sp;
endmodule

// File: rtl/stack_call_unit_chk.sv
module stack_call_unit_chk #(
  parameter int         AW     = 8,
  parameter int         DW     = 8,
  parameter logic [7:0] SP_RST = 8'h07
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic [2*DW-1:0] pc_out,
  input logic [AW-1:0]   sp_out,
  input logic            busy,
  input logic            done
);
  logic acc;
  assign acc = cmd_valid && !busy;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sp_out == AW'(SP_RST) && !busy && !done));

  assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b00) |=>
      (sp_out == AW'($past(sp_out) + 1'b1) && done && !busy));

  assert_pop_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b01) |=>
      (busy && !done && sp_out == AW'($past(sp_out) - 1'b1)));

  assert_call_first_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b10) |=>
      (busy && !done && sp_out == AW'($past(sp_out) + 1'b1)));

  assert_ret_first_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b11) |=>
      (busy && !done && sp_out == AW'($past(sp_out) - 1'b1)));

  assert_pc_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_out) |-> done);
endmodule

bind stack_call_unit stack_call_unit_chk #(.AW(AW), .DW(DW), .SP_RST(SP_RST)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .pc_out(pc_out), .sp_out(sp_out), .busy(busy), .done(done)
);

// File: tb/stack_call_unit_tb_top.sv
`timescale 1ns/1ps
module stack_call_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [7:0]  push_data = 8'h00;
  logic [15:0] ret_pc = 16'h0000;
  logic [15:0] call_tgt = 16'h0000;
  logic [7:0]  pop_data;
  logic [15:0] pc_out;
  logic [7:0]  sp_out;
  logic        busy, done;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_sp;

  always #2 clk = ~clk;

  stack_call_unit dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .push_data(push_data), .ret_pc(ret_pc), .call_tgt(call_tgt),
    .pop_data(pop_data), .pc_out(pc_out), .sp_out(sp_out),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=%0d expected below %0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] d,
                       input logic [15:0] ra, input logic [15:0] tg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; push_data = d; ret_pc = ra; call_tgt = tg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_push(input logic [7:0] d);
    issue(2'b00, d, 16'h0, 16'h0);
    ref_sp = ref_sp + 8'd1;
    ref_mem[ref_sp] = d;
    chk(done == 1'b1, "R2", "push done", {31'd0, done}, 1);
    chk(busy == 1'b0, "R2", "push busy", {31'd0, busy}, 0);
    chk(sp_out == ref_sp, "R2/R7", "push sp", {24'd0, sp_out}, {24'd0, ref_sp});
  endtask

  task automatic do_pop(input bit inject);
    logic [7:0] exp;
    exp = ref_mem[ref_sp];
    issue(2'b01, 8'h00, 16'h0, 16'h0);
    chk(busy == 1'b1, "R3", "pop busy", {31'd0, busy}, 1);
    chk(done == 1'b0, "R3", "pop early done", {31'd0, done}, 0);
    if (inject) begin
      cmd_valid = 1'b1; cmd_op = 2'b00; push_data = 8'hEE;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    ref_sp = ref_sp - 8'd1;
    chk(done == 1'b1, "R3", "pop done", {31'd0, done}, 1);
    chk(pop_data == exp, "R3", "pop data", {24'd0, pop_data}, {24'd0, exp});
    chk(sp_out == ref_sp, inject ? "R6" : "R3/R7", "pop sp", {24'd0, sp_out}, {24'd0, ref_sp});
  endtask

  task automatic do_call(input logic [15:0] ra, input logic [15:0] tg, input bit inject);
    issue(2'b10, 8'h00, ra, tg);
    chk(busy == 1'b1, "R4", "call busy", {31'd0, busy}, 1);
    if (inject) begin
      cmd_valid = 1'b1; cmd_op = 2'b00; push_data = 8'hA5;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    ref_sp = ref_sp + 8'd1; ref_mem[ref_sp] = ra[7:0];
    ref_sp = ref_sp + 8'd1; ref_mem[ref_sp] = ra[15:8];
    chk(done == 1'b1, "R4", "call done", {31'd0, done}, 1);
    chk(busy == 1'b0, "R4", "call busy end", {31'd0, busy}, 0);
    chk(pc_out == tg, "R4", "call pc", {16'd0, pc_out}, {16'd0, tg});
    chk(sp_out == ref_sp, inject ? "R6" : "R4", "call sp", {24'd0, sp_out}, {24'd0, ref_sp});
  endtask

  task automatic do_ret(input bit inject);
    logic [15:0] exp;
    exp = {ref_mem[ref_sp], ref_mem[ref_sp - 8'd1]};
    issue(2'b11, 8'h00, 16'h0, 16'h0);
    chk(busy == 1'b1, "R5", "ret busy 1", {31'd0, busy}, 1);
    if (inject) begin
      cmd_valid = 1'b1; cmd_op = 2'b10; ret_pc = 16'hDEAD; call_tgt = 16'hBEEF;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R5", "ret busy 2", {31'd0, busy}, 1);
    chk(done == 1'b0, "R5", "ret early done", {31'd0, done}, 0);
    @(negedge clk);
    ref_sp = ref_sp - 8'd2;
    chk(done == 1'b1, "R5", "ret done", {31'd0, done}, 1);
    chk(pc_out == exp, inject ? "R6" : "R5", "ret pc", {16'd0, pc_out}, {16'd0, exp});
    chk(sp_out == ref_sp, "R5", "ret sp", {24'd0, sp_out}, {24'd0, ref_sp});
  endtask

  task automatic idle_check();
    logic [15:0] pc_keep;
    logic [7:0]  pd_keep;
    pc_keep = pc_out; pd_keep = pop_data;
    @(negedge clk);
    chk(done == 1'b0, "R8", "done pulse width", {31'd0, done}, 0);
    chk(pc_out == pc_keep, "R8", "pc hold", {16'd0, pc_out}, {16'd0, pc_keep});
    chk(pop_data == pd_keep, "R8", "pop_data hold", {24'd0, pop_data}, {24'd0, pd_keep});
  endtask

  initial begin
    ref_sp = 8'h07;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(sp_out == 8'h07, "R1", "reset sp", {24'd0, sp_out}, 32'h07);
    chk(busy == 1'b0 && done == 1'b0, "R1", "reset flags", {30'd0, busy, done}, 0);
    chk(pc_out == 16'h0 && pop_data == 8'h0, "R1", "reset outputs",
        {8'd0, pc_out, pop_data}, 0);

    // worked push example, R2
    do_push(8'h55);
    do_push(8'h4A);
    chk(sp_out == 8'h09, "R2", "two pushes sp", {24'd0, sp_out}, 32'h09);
    idle_check();
    do_pop(1'b0);
    chk(pop_data == 8'h4A, "R3", "first pop", {24'd0, pop_data}, 32'h4A);
    idle_check();
    do_pop(1'b0);
    chk(pop_data == 8'h55, "R3", "second pop", {24'd0, pop_data}, 32'h55);

    // R9 call example from pointer 3AH
    for (int i = 0; i < 8'h33; i++) do_push(8'(i * 3 + 1));
    chk(sp_out == 8'h3A, "R9", "pointer before call", {24'd0, sp_out}, 32'h3A);
    do_call(16'h0207, 16'h043A, 1'b0);
    chk(sp_out == 8'h3C, "R9", "pointer after call", {24'd0, sp_out}, 32'h3C);
    idle_check();
    do_pop(1'b0);
    chk(pop_data == 8'h02, "R9", "byte at 3CH", {24'd0, pop_data}, 32'h02);
    do_pop(1'b0);
    chk(pop_data == 8'h07, "R9", "byte at 3BH", {24'd0, pop_data}, 32'h07);
    for (int i = 0; i < 8'h33; i++) do_pop(1'b0);

    // R7 full ring sweep through FFH -> 00H and back
    for (int i = 0; i < 256; i++) do_push(8'(i * 37 + 11));
    for (int i = 0; i < 256; i++) do_pop(i % 17 == 0);

    // nested calls and returns, R4 R5 R6
    for (int i = 0; i < 24; i++)
      do_call(16'(i * 16'h1357 + 16'h0204), 16'(i * 16'h0B0D + 16'h4000), i % 5 == 0);
    for (int i = 0; i < 24; i++) begin
      do_ret(i % 4 == 0);
      chk(pc_out == 16'((23 - i) * 16'h1357 + 16'h0204), "R5", "ret arith",
          {16'd0, pc_out}, {16'd0, 16'((23 - i) * 16'h1357 + 16'h0204)});
    end
    idle_check();
    chk(sp_out == 8'h07, "R6", "final sp", {24'd0, sp_out}, 32'h07);

    // R7 pop wraps 00H -> FFH
    for (int i = 0; i < 8; i++) do_pop(1'b0);
    chk(sp_out == 8'hFF, "R7", "pop wrap", {24'd0, sp_out}, 32'hFF);
    do_push(8'h3C);
    chk(sp_out == 8'h00, "R7", "push wrap", {24'd0, sp_out}, 32'h00);

    finish_run();
  end
endmodule